// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This controller places a direct-mapped, write-back, write-allocate cache between a processor request port and a main-memory port that moves one word at a time. Every word address has three fields. The top field is a tag. The middle field selects the single line the block may occupy. The bottom field picks a word inside that line. A lookup therefore compares exactly one stored tag. Hits are answered from the internal data array. A miss replaces the resident line. If that line is valid and dirty, the controller first writes all its words back to memory, then reads the whole new block in, and then finishes the original request.

Writes change only the cache and mark the line dirty. Memory sees the data only when the line is evicted. A separate invalidate input lets a DMA engine report a block it has overwritten in memory. If that block is resident, its line is dropped without a write-back, so the next access fetches the fresh data.

Top module: `dm_wb_cache`

## Requirements
- R1: A word address is split, most significant first, into a TAG_W tag, an IDX_W line index and an OFF_W word offset. Block {tag,index} may only live in line index. Two addresses with the same tag and index but different offsets hit the same line.
- R2: After reset, every line is invalid and clean, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R3: A read hit returns the stored word on `resp_rdata` and causes no memory traffic.
- R4: A write hit stores the word in the cache only, sets the line dirty and causes no memory write. Its response returns the written word.
- R5: A write miss allocates the line: the block is read in first, then the write is applied and the line is marked dirty.
- R6: A miss whose victim line is valid and dirty first writes back all 2^OFF_W words of the victim to the victim's own block address. No fill read is issued before this write-back completes.
- R7: A miss whose victim line is clean or invalid issues no memory write.
- R8: A fill reads exactly 2^OFF_W words, in ascending offset order starting at offset 0. Write-back beats use the same order. The processor response comes only after the fill.
- R9: The processor port uses valid/ready. After a request is accepted, `req_ready` stays 0 until its response. `resp_valid` is a single-cycle pulse for every request.
- R10: A pulse on `inv_valid` with `inv_block` = {tag,index} clears the valid and dirty bits of that line if it holds that block. The next access to that block refetches it from memory. An invalidate naming a block that is not resident changes nothing.
- R11: On the memory port, `mem_req` with `mem_we`, `mem_addr` and `mem_wdata` holds steady until `mem_ack`. Each acknowledged beat moves one word; read data is taken from `mem_rdata` in the acknowledged cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | TAG_W+IDX_W+OFF_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | DATA_W | Read word, or written word for writes |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | TAG_W+IDX_W+OFF_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory accepts or returns the current beat |
| mem_rdata | input | DATA_W | Fill data |
| inv_valid | input | 1 | DMA invalidate pulse |
| inv_block | input | TAG_W+IDX_W | Block address overwritten by DMA |

## Verification
The bench builds the controller with a 3-bit tag, a 2-bit index, a 2-bit offset and 16-bit data. This gives four lines of four words over a 128-word memory, so conflict misses, dirty evictions and full line bursts happen within a few requests. A bench memory that acknowledges only every other cycle exercises the hold rules of the memory port. A flush of every dirty line at the end lets the whole memory image be compared with a reference copy. DMA overwrites followed by invalidates, including one that names an absent block, show that stale lines are dropped and that resident lines for other blocks are left alone.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int TAG_W  = 9,
  parameter int IDX_W  = 5,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]              req_wdata,
  output logic                           resp_valid,
  output logic [DATA_W-1:0]              resp_rdata,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  input  logic                           mem_ack,
  input  logic [DATA_W-1:0]              mem_rdata,
  input  logic                           inv_valid,
  input  logic [TAG_W+IDX_W-1:0]         inv_block
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_TAG, S_WB, S_FILL} state_t;
  state_t st;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES*WORDS];
  logic [LINES-1:0]  valid_q, dirty_q;

  logic              r_we;
  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic [OFF_W-1:0]  r_off, cnt;
  logic [DATA_W-1:0] r_wdata;

  logic [TAG_W-1:0] inv_tag;
  logic [IDX_W-1:0] inv_idx;
  logic hit, inv_hit, last_beat;

  assign inv_tag   = inv_block[TAG_W+IDX_W-1:IDX_W];
  assign inv_idx   = inv_block[IDX_W-1:0];
  assign inv_hit   = inv_valid && valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
  assign hit       = valid_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign last_beat = mem_ack && (&cnt);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_WB) || (st == S_FILL);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = {(st == S_WB) ? tag_q[r_idx] : r_tag, r_idx, cnt};
  assign mem_wdata = data_q[{r_idx, cnt}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      valid_q    <= '0;
      dirty_q    <= '0;
      cnt        <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      r_we       <= 1'b0;
      r_tag      <= '0;
      r_idx      <= '0;
      r_off      <= '0;
      r_wdata    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          r_we    <= req_we;
          r_tag   <= req_addr[TAG_W+IDX_W+OFF_W-1:IDX_W+OFF_W];
          r_idx   <= req_addr[IDX_W+OFF_W-1:OFF_W];
          r_off   <= req_addr[OFF_W-1:0];
          r_wdata <= req_wdata;
          st      <= S_TAG;
        end
        S_TAG: if (hit) begin
          resp_valid <= 1'b1;
          resp_rdata <= r_we ? r_wdata : data_q[{r_idx, r_off}];
          if (r_we) dirty_q[r_idx] <= 1'b1;
          st <= S_IDLE;
        end else begin
          valid_q[r_idx] <= 1'b0;
          cnt <= '0;
          st  <= (valid_q[r_idx] && dirty_q[r_idx]) ? S_WB : S_FILL;
        end
        S_WB: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last_beat) begin
            dirty_q[r_idx] <= 1'b0;
            st <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          cnt <= cnt + 1'b1;
          if (last_beat) begin
            valid_q[r_idx] <= 1'b1;
            dirty_q[r_idx] <= 1'b0;
            st <= S_TAG;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (inv_hit) begin
        valid_q[inv_idx] <= 1'b0;
        dirty_q[inv_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_FILL && mem_ack) data_q[{r_idx, cnt}] <= mem_rdata;
    if (st == S_TAG && hit && r_we) data_q[{r_idx, r_off}] <= r_wdata;
    if (st == S_FILL && last_beat) tag_q[r_idx] <= r_tag;
  end

  // R9
  accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R9
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R6
  fill_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !dirty_q[r_idx]);
  // R4
  write_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TAG && hit && r_we && !inv_valid |=> dirty_q[r_idx]);
  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_hit |=> !valid_q[$past(inv_idx)]);
endmodule

// File: tb/tb_dm_wb_cache.sv
module tb_dm_wb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 3, IW = 2, OW = 2, DW = 16;
  localparam int AW = TW + IW + OW;
  localparam int LINES = 1 << IW, WORDS = 1 << OW, MSZ = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, inv_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [TW+IW-1:0] inv_block = '0;
  logic req_ready, resp_valid, mem_req, mem_we, mem_ack;
  logic [DW-1:0] resp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic ack_en = 0;

  logic [DW-1:0] bmem [MSZ];
  logic [DW-1:0] refm [MSZ];
  logic [TW-1:0] sh_tag [LINES];
  logic sh_valid [LINES];
  logic sh_dirty [LINES];

  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  int nchecks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, order_err = 0, resp_cnt = 0;
  logic seen_rd = 0;
  logic [OW-1:0] beat_pos = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ack_en <= ~ack_en;
  assign mem_ack   = mem_req & ack_en;
  assign mem_rdata = bmem[mem_addr];

  dm_wb_cache #(.TAG_W(TW), .IDX_W(IW), .OFF_W(OW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .inv_valid(inv_valid), .inv_block(inv_block));

  task automatic check(input logic ok, input string rq, input int act, input int expv);
    nchecks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
    end
  endtask

  // memory model and beat monitor (R8, R6)
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_addr[OW-1:0] != beat_pos) order_err++;
      beat_pos = beat_pos + 1'b1;
      if (mem_we) begin
        if (seen_rd) order_err++;
        bmem[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        seen_rd = 1;
        rd_cnt++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected response", 1, 0);
      else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(resp_rdata == e, t, int'(resp_rdata), int'(e));
      end
      resp_cnt++;
    end
  end

  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    logic [TW-1:0] t; logic [IW-1:0] ix;
    logic hit; int exp_wb, exp_rd, wr0, rd0, r0;
    string rq;
    t  = a[AW-1:IW+OW];
    ix = a[IW+OW-1:OW];
    hit = sh_valid[ix] && sh_tag[ix] == t;
    exp_wb = (!hit && sh_valid[ix] && sh_dirty[ix]) ? WORDS : 0;
    exp_rd = hit ? 0 : WORDS;
    if (we) refm[a] = wd;
    sh_dirty[ix] = hit ? (sh_dirty[ix] | we) : we;
    sh_valid[ix] = 1; sh_tag[ix] = t;
    rq = hit ? (we ? "R4 write hit" : "R3 read hit") : (we ? "R5 write miss" : "R8 read miss");
    exp_q.push_back(refm[a]);
    tag_q.push_back({rq, " data"});
    wr0 = wr_cnt; rd0 = rd_cnt; r0 = resp_cnt; order_err = 0; seen_rd = 0;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R9 ready low while busy", int'(req_ready), 0);
    wait (resp_cnt != r0);
    check(wr_cnt - wr0 == exp_wb, exp_wb != 0 ? "R6 write-back beats" : "R7 no write-back", wr_cnt - wr0, exp_wb);
    check(rd_cnt - rd0 == exp_rd, hit ? "R3 no fill on hit" : "R8 fill beats", rd_cnt - rd0, exp_rd);
    check(order_err == 0, "R8 beat order", order_err, 0);
  endtask

  task automatic dma(input logic [TW+IW-1:0] blk, input logic [DW-1:0] seed);
    logic [IW-1:0] ix;
    for (int w = 0; w < WORDS; w++) begin
      bmem[{blk, w[OW-1:0]}] = seed + DW'(w);
      refm[{blk, w[OW-1:0]}] = seed + DW'(w);
    end
    ix = blk[IW-1:0];
    if (sh_valid[ix] && sh_tag[ix] == blk[TW+IW-1:IW]) begin
      sh_valid[ix] = 0; sh_dirty[ix] = 0;
    end
    @(negedge clk);
    inv_valid = 1; inv_block = blk;
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic inv_only(input logic [TW+IW-1:0] blk);
    @(negedge clk);
    inv_valid = 1; inv_block = blk;
    @(negedge clk);
    inv_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; nchecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int mism;
    for (int i = 0; i < MSZ; i++) begin
      bmem[i] = DW'(i * 37 + 5);
      refm[i] = DW'(i * 37 + 5);
    end
    for (int i = 0; i < LINES; i++) begin
      sh_valid[i] = 0; sh_dirty[i] = 0; sh_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R2 ready in reset", int'(req_ready), 1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R2 ready after reset", int'(req_ready), 1);
    check(resp_valid == 0, "R2 no response", int'(resp_valid), 0);
    check(mem_req == 0, "R2 no memory request", int'(mem_req), 0);

    access(0, {3'd1, 2'd0, 2'd1}, '0);        // R8 cold miss
    access(0, {3'd1, 2'd0, 2'd3}, '0);        // R1 same block, other offset hits
    access(1, {3'd1, 2'd0, 2'd2}, 16'hBEEF);  // R4 write hit
    access(0, {3'd1, 2'd0, 2'd2}, '0);        // R3 read back
    access(0, {3'd5, 2'd0, 2'd0}, '0);        // R6 dirty victim, R1 conflict
    mism = 0;
    for (int w = 0; w < WORDS; w++)
      if (bmem[{3'd1, 2'd0, w[OW-1:0]}] != refm[{3'd1, 2'd0, w[OW-1:0]}]) mism++;
    check(mism == 0, "R6 victim block in memory", mism, 0);
    access(1, {3'd2, 2'd1, 2'd3}, 16'h1234);  // R5 write allocate
    access(0, {3'd2, 2'd1, 2'd3}, '0);        // R5 read back
    inv_only({3'd6, 2'd1});                   // R10 absent block
    access(0, {3'd2, 2'd1, 2'd0}, '0);        // R10 still hits
    dma({3'd2, 2'd1}, 16'h7000);              // R10 resident, dirty
    access(0, {3'd2, 2'd1, 2'd3}, '0);        // R10 refetch, no write-back

    lfsr = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (k % 40 == 39) dma(lfsr[TW+IW-1:0], lfsr ^ 16'h5A5A);
      else access(lfsr[8], lfsr[AW-1:0], lfsr ^ DW'(k));
    end

    for (int i = 0; i < LINES; i++)
      if (sh_valid[i] && sh_dirty[i])
        access(0, {sh_tag[i] + 1'b1, i[IW-1:0], {OW{1'b0}}}, '0);
    mism = 0;
    for (int i = 0; i < MSZ; i++) if (bmem[i] != refm[i]) mism++;
    check(mism == 0, "R6 memory image after flush", mism, 0);
    check(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, errors);
    $finish;
  end
endmodule